// File: doc/BRIEF.md
# Cache Line Health Status Tracker

This block watches a stream of corrected-ECC events. Each event names the cache line (ECC block) that the decoder had to fix. For every line the block keeps a small saturating record, so it can tell a line corrected once from a line corrected again. It counts the distinct lines that have needed more than one correction. It compares that count with a threshold fixed at build time and drives a two-level health flag: green (0) or yellow (1).

Yellow is a maintenance warning only. Uncorrected errors travel on their own path through the block, registered once, and nothing on that path depends on the health flag. A capability bit, tied high, tells a status register that threshold-based health reporting is present. A synchronous clear wipes every per-line record, the count and the flag.

Top module: `cache_health_tracker`

## Requirements
- R1: After reset `status_o` is 0, `affected_cnt_o` is 0 and `unc_o` is 0.
- R2: `cap_o` reads 1 at all times.
- R3: The first accepted correction of a line leaves `affected_cnt_o` unchanged. With no accepted event and no clear, the count holds.
- R4: The second accepted correction of a line raises `affected_cnt_o` by exactly 1. The change shows on the clock edge that samples the event.
- R5: Third and later corrections of an already-repeated line leave `affected_cnt_o` unchanged. The total number of correction events never drives the count.
- R6: `status_o` is 0 while the affected-line count is at or below `THRESHOLD`.
- R7: `status_o` becomes 1 on the same edge where the count first exceeds `THRESHOLD`.
- R8: `affected_cnt_o` saturates at 2**`CNT_W`-1 and never wraps.
- R9: Once `status_o` is 1 it stays 1 until `clr_i`. `clr_i` zeroes every per-line record, the count and the status on the next edge. An event presented in the same cycle as `clr_i` is dropped.
- R10: `unc_o` equals `unc_i` from the previous cycle, whatever the health status. Yellow never sets `unc_o`.
- R11: An event whose `evt_line_i` is `NUM_LINES` or higher is ignored and touches no line record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all tracking state |
| evt_valid_i | input | 1 | A corrected-error event is presented this cycle |
| evt_line_i | input | IDX_W | Line index of the corrected event |
| unc_i | input | 1 | Uncorrected error indication from the separate path |
| status_o | output | 1 | Health flag: 0 green, 1 yellow |
| affected_cnt_o | output | CNT_W | Number of distinct lines with repeated corrections |
| unc_o | output | 1 | Registered uncorrected error flag |
| cap_o | output | 1 | Threshold-status capability, constant 1 |

## Verification
The bench builds the tracker with `NUM_LINES`=6, `CNT_W`=2 and `THRESHOLD`=1. Six lines need a 3-bit index, so indices 6 and 7 exercise the out-of-range rule. A 2-bit counter is reached after only three repeated lines, so saturation can be tested. A threshold of 1 lets one vector sequence cover green, the switch to yellow, sticky yellow, and a clear that collides with an event.

// File: rtl/health_pkg.sv
// Package: shared per-line state encoding for the health tracker.
// Assumes: a 2-bit state per line is enough (none, once, repeated).
package health_pkg;
    typedef enum logic [1:0] {
        LS_NONE   = 2'd0,
        LS_ONCE   = 2'd1,
        LS_REPEAT = 2'd2
    } line_state_e;
endpackage

// File: rtl/line_state_table.sv
// Module: line_state_table
// Keeps one saturating state per cache line. It pulses promote_o when an
// accepted event moves a line from seen-once to repeated.
// Assumes: at most one event per cycle. Indices >= NUM_LINES match no line.
module line_state_table
    import health_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_valid_i,
    input  logic [IDX_W-1:0] evt_line_i,
    output logic             promote_o
);
    logic [NUM_LINES-1:0] promote_vec;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e st_q;
        logic        hit;

        // Decode whether this cycle's event targets this line.
        always_comb begin
            hit = evt_valid_i && !clr_i && (evt_line_i == IDX_W'(g));
        end

        // Advance the per-line saturating state; a clear wipes it.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                st_q <= LS_NONE;
            end else if (hit) begin
                case (st_q)
                    LS_NONE: st_q <= LS_ONCE;
                    default: st_q <= LS_REPEAT;
                endcase
            end
        end

        // Flag the one-time move from seen-once to repeated.
        always_comb begin
            promote_vec[g] = hit && (st_q == LS_ONCE);
        end
    end

    // Combine the per-line promotion flags.
    always_comb begin
        promote_o = |promote_vec;
    end
endmodule

// File: rtl/affected_counter.sv
// Module: affected_counter
// A saturating count of lines that have had repeated corrections. It also
// exposes its next value so the status stage can update on the same edge.
// Assumes: promote_i pulses at most once per cycle.
module affected_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             promote_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Work out the next count, holding at the maximum.
    always_comb begin
        if (clr_i) begin
            cnt_next_o = '0;
        end else if (promote_i && (cnt_q != CNT_MAX)) begin
            cnt_next_o = cnt_q + 1'b1;
        end else begin
            cnt_next_o = cnt_q;
        end
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next_o;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/health_status.sv
// Module: health_status
// Sticky two-level health flag: it goes yellow once the count exceeds the
// threshold, and only a clear returns it to green.
// Assumes: THRESHOLD fits in CNT_W bits and is below the counter maximum.
module health_status #(
    parameter int CNT_W     = 7,
    parameter int THRESHOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output logic             yellow_o
);
    localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESHOLD);

    logic yellow_q;

    // Latch yellow once the next count exceeds the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            yellow_q <= 1'b0;
        end else if (cnt_next_i > THR_C) begin
            yellow_q <= 1'b1;
        end
    end

    assign yellow_o = yellow_q;
endmodule

// File: rtl/cache_health_tracker.sv
// Module: cache_health_tracker (top)
// Tracks corrected-ECC events per cache line and reports a green/yellow
// health flag from the number of lines with repeated corrections. Passes
// uncorrected errors through a separate, independent register.
// Assumes: one event per cycle; clear has priority over an event.
module cache_health_tracker #(
    parameter int NUM_LINES = 64,
    parameter int THRESHOLD = 4,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_valid_i,
    input  logic [IDX_W-1:0] evt_line_i,
    input  logic             unc_i,
    output logic             status_o,
    output logic [CNT_W-1:0] affected_cnt_o,
    output logic             unc_o,
    output logic             cap_o
);
    logic             promote;
    logic [CNT_W-1:0] cnt_next;
    logic             unc_q;

    line_state_table #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .evt_valid_i (evt_valid_i),
        .evt_line_i  (evt_line_i),
        .promote_o   (promote)
    );

    affected_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .promote_i  (promote),
        .cnt_o      (affected_cnt_o),
        .cnt_next_o (cnt_next)
    );

    health_status #(
        .CNT_W     (CNT_W),
        .THRESHOLD (THRESHOLD)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .cnt_next_i (cnt_next),
        .yellow_o   (status_o)
    );

    // Register the uncorrected-error flag, independent of health status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_q <= 1'b0;
        end else begin
            unc_q <= unc_i;
        end
    end

    assign unc_o = unc_q;
    assign cap_o = 1'b1;
endmodule

// File: rtl/health_tracker_chk.sv
// Module: health_tracker_chk
// Property checker for cache_health_tracker, attached by bind below.
module health_tracker_chk #(
    parameter int CNT_W     = 7,
    parameter int THRESHOLD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             evt_valid_i,
    input logic             unc_i,
    input logic             status_o,
    input logic [CNT_W-1:0] affected_cnt_o,
    input logic             unc_o,
    input logic             cap_o
);
    localparam logic [CNT_W-1:0] MAX_C = '1;
    localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESHOLD);

    // R2
    cap_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o == 1'b1);

    // R3
    cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid_i && !clr_i) |=> $stable(affected_cnt_o));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (affected_cnt_o == $past(affected_cnt_o)) ||
                   (affected_cnt_o == $past(affected_cnt_o) + 1'b1));

    // R6
    green_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |-> (affected_cnt_o > THR_C));

    // R7
    yellow_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (affected_cnt_o > THR_C) |-> status_o);

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (affected_cnt_o == MAX_C && !clr_i) |=> affected_cnt_o == MAX_C);

    // R9
    yellow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i) |=> status_o);

    // R9
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (affected_cnt_o == '0) && !status_o);

    // R10
    unc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> unc_o == $past(unc_i));
endmodule

bind cache_health_tracker health_tracker_chk #(
    .CNT_W     (CNT_W),
    .THRESHOLD (THRESHOLD)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (clr_i),
    .evt_valid_i    (evt_valid_i),
    .unc_i          (unc_i),
    .status_o       (status_o),
    .affected_cnt_o (affected_cnt_o),
    .unc_o          (unc_o),
    .cap_o          (cap_o)
);

// File: tb/cache_health_tracker_bench.sv
// Scoreboard bench for cache_health_tracker.
module cache_health_tracker_bench;
    localparam int NL    = 6;
    localparam int THR   = 1;
    localparam int CW    = 2;
    localparam int IW    = 3;
    localparam int CMAX  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic          evt_valid_i = 1'b0;
    logic [IW-1:0] evt_line_i = '0;
    logic          unc_i = 1'b0;
    logic          status_o;
    logic [CW-1:0] affected_cnt_o;
    logic          unc_o;
    logic          cap_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    typedef struct {
        int    cnt;
        bit    yel;
        bit    unc;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    int m_st[NL];
    int m_cnt = 0;
    bit m_yel = 1'b0;

    always #4 clk = ~clk;

    cache_health_tracker #(
        .NUM_LINES (NL),
        .THRESHOLD (THR),
        .IDX_W     (IW),
        .CNT_W     (CW)
    ) u_cache_health_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (clr_i),
        .evt_valid_i    (evt_valid_i),
        .evt_line_i     (evt_line_i),
        .unc_i          (unc_i),
        .status_o       (status_o),
        .affected_cnt_o (affected_cnt_o),
        .unc_o          (unc_o),
        .cap_o          (cap_o)
    );

    // Driver: present one cycle of stimulus and push the model's expectation.
    task automatic apply(input bit v, input int idx, input bit clr,
                         input bit unc, input string tag);
        exp_t e;
        @(negedge clk);
        evt_valid_i = v;
        evt_line_i  = IW'(idx);
        clr_i       = clr;
        unc_i       = unc;
        if (clr) begin
            for (int i = 0; i < NL; i++) m_st[i] = 0;
            m_cnt = 0;
            m_yel = 1'b0;
        end else if (v && idx < NL) begin
            if (m_st[idx] == 1 && m_cnt < CMAX) m_cnt++;
            if (m_st[idx] < 2) m_st[idx]++;
            if (m_cnt > THR) m_yel = 1'b1;
        end
        e.cnt = m_cnt;
        e.yel = m_yel;
        e.unc = unc;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: after each edge, compare outputs against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (int'(affected_cnt_o) != e.cnt || status_o != e.yel ||
                    unc_o != e.unc || cap_o != 1'b1) begin
                    fails++;
                    $display("FAIL %s: cnt=%0d status=%0b unc=%0b cap=%0b expected cnt=%0d status=%0b unc=%0b cap=1",
                             e.tag, affected_cnt_o, status_o, unc_o, cap_o,
                             e.cnt, e.yel, e.unc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        done = 1'b1;
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < NL; i++) m_st[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        vectors++;
        if (status_o !== 1'b0 || affected_cnt_o !== '0 || unc_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: cnt=%0d status=%0b unc=%0b expected 0 0 0",
                     affected_cnt_o, status_o, unc_o);
        end
        apply(0, 0, 0, 0, "R1 idle");
        apply(1, 0, 0, 1, "R3 first hit line0 / R10");
        apply(1, 0, 0, 0, "R4 second hit line0 / R6 green at threshold");
        apply(1, 0, 0, 1, "R5 third hit line0 / R10 unc while green");
        apply(1, 6, 0, 0, "R11 index 6 ignored");
        apply(1, 6, 0, 0, "R11 index 6 again ignored");
        apply(1, 7, 0, 0, "R11 index 7 ignored");
        apply(1, 1, 0, 0, "R3 first hit line1");
        apply(1, 2, 0, 0, "R3 first hit line2");
        apply(0, 1, 0, 0, "R3 idle hold");
        apply(1, 1, 0, 0, "R7 line1 repeat goes yellow");
        apply(0, 0, 0, 1, "R10 unc while yellow");
        apply(0, 0, 0, 0, "R10 yellow leaves unc low");
        apply(1, 2, 0, 0, "R8 line2 repeat reaches max");
        apply(1, 3, 0, 0, "R3 first hit line3");
        apply(1, 3, 0, 0, "R8 saturate line3");
        apply(1, 4, 0, 0, "R8 first hit line4");
        apply(1, 4, 0, 0, "R8 saturate line4");
        for (int k = 0; k < 4; k++) apply(0, 0, 0, 0, "R9 yellow sticky");
        apply(1, 5, 1, 0, "R9 clear wins over event");
        apply(1, 5, 0, 0, "R9 dropped event not recorded");
        apply(1, 0, 0, 0, "R9 clear wiped line0 record");
        apply(1, 0, 0, 0, "R4 line0 repeat after clear");
        apply(1, 5, 0, 0, "R4 line5 repeat after clear goes yellow");
        apply(0, 0, 0, 0, "R7 yellow again");
        apply(0, 0, 1, 0, "R9 clear alone");
        apply(0, 0, 0, 0, "R6 green after clear");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // Summary.
    initial begin
        wait (done);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule